// File: doc/BRIEF.md
# Start-End Timer Base Counter

This block is the base unit of a general-purpose timer. An up-counter runs from a programmable start value to a programmable end value. One tick past the end value it wraps back to the start value and raises an overflow. The counter advances on a tick from a prescaler. The prescaler divides either the core clock or edges seen on an external clock pin, and software picks the pin edges that count.

Software sets the block up through a simple register-write port and can also pulse a software update strobe. This strobe restarts the count and, depending on the control bits, raises an update event. The update event reloads the buffered end value when end-value buffering is on. Overflow and update each set a sticky flag. The interrupt line is the OR of the flags whose interrupt enable is set. The timer can run continuously, or stop itself after its first overflow.

Top module: `span_timer`

## Requirements
- R1: After reset the count is 0, the run bit is clear, both flags are clear, and `irq_o`, `update_o` and `overflow_o` are low.
- R2: With the internal clock and prescaler 0, the count rises by one each cycle up to the end value. On the next tick it returns to the start value, and `overflow_o` pulses for the one cycle in which the count shows the start value. In continuous mode this repeats.
- R3: With prescaler value N, the counter advances once every N+1 source ticks. Register select 1 writes the prescaler.
- R4: Control bits [6:5] select the count source: 0 is the internal clock, 1 is rising edges of `ext_clk_i`, 2 is falling edges, and 3 is both edges. An external edge reaches the count three clock edges after the pin changes. Edges not selected have no effect, and neither do core clock cycles.
- R5: When control bit 1 (one-shot) is set, the first overflow loads the start value and clears the run bit (control bit 0). The count then stays put.
- R6: A one-cycle pulse on `ugen_i` loads the start value into the counter and clears the prescaler phase. It also raises an update event, with `update_o` high the next cycle and the update flag set.
- R7: With control bit 3 (overflow-only) set, `ugen_i` still restarts the count but raises no update. An overflow still raises one.
- R8: With control bit 2 (update-off) set, no update event occurs: `update_o` stays low, the update flag is not set and the buffered end value is not loaded. The overflow flag is still set.
- R9: Register select 3 writes the end value. With control bit 4 (buffer) set, the new value is used only after the next update event. With bit 4 clear, it is used at once.
- R10: Flags are sticky: bit 0 is overflow and bit 1 is update. Writing register select 5 clears each flag whose data bit is 1, and a 0 bit leaves that flag alone. `irq_o` is the OR of overflow-flag-and-control-bit-7 with update-flag-and-control-bit-8.
- R11: Clearing the run bit freezes both the counter and the prescaler phase. Writing register select 4 loads the counter directly and clears the prescaler phase. Select 0 writes control and select 2 writes the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select: 0 control, 1 prescaler, 2 start, 3 end, 4 counter, 5 flag clear |
| wr_data_i | input | DATA_W | Write data |
| ugen_i | input | 1 | Software update-generate pulse |
| count_o | output | CNT_W | Current counter value |
| update_o | output | 1 | One-cycle update event pulse |
| overflow_o | output | 1 | One-cycle overflow pulse |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| upd_flag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Interrupt request |
| run_o | output | 1 | Counter enable state |

## Verification
The case hardest to reach from the ports is a buffered end value that must not be used until an update. Seeing it needs a full period still bounded by the old end value while the new one waits. The stimulus writes a new end value early in a period with buffering on, runs to overflow and records the highest count, then runs a second period and expects the new bound. The same pattern is repeated with update-off set, and there the old bound must hold for two periods in a row. External edge modes are driven by toggling the pin between clock edges, and the counter is sampled exactly three edges later.

// File: rtl/span_timer_pkg.sv
package span_timer_pkg;

  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_PRESC = 3'd1;
  localparam logic [SEL_W-1:0] SEL_START = 3'd2;
  localparam logic [SEL_W-1:0] SEL_END   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_COUNT = 3'd4;
  localparam logic [SEL_W-1:0] SEL_FLAGS = 3'd5;

  typedef enum logic [1:0] {
    SRC_CORE = 2'd0,
    SRC_RISE = 2'd1,
    SRC_FALL = 2'd2,
    SRC_BOTH = 2'd3
  } clk_src_e;

  typedef struct packed {
    logic     upd_ie;    // [8]
    logic     ovf_ie;    // [7]
    clk_src_e clk_src;   // [6:5]
    logic     buf_en;    // [4]
    logic     ovf_only;  // [3]
    logic     upd_off;   // [2]
    logic     one_shot;  // [1]
    logic     run;       // [0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/span_timer_tick.sv
module span_timer_tick
  import span_timer_pkg::*;
#(
  parameter int PSC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  clk_src_e         src_i,
  input  logic             run_i,
  input  logic             phase_clr_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_s;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= ext_clk_i;
      end
    end
  endgenerate

  assign ext_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= ext_s;
  end

  logic src_tick;
  always_comb begin
    unique case (src_i)
      SRC_CORE: src_tick = 1'b1;
      SRC_RISE: src_tick = ext_s & ~prev_q;
      SRC_FALL: src_tick = ~ext_s & prev_q;
      default:  src_tick = ext_s ^ prev_q;
    endcase
  end

  logic [PSC_W-1:0] phase_q;
  logic             wrap;

  assign wrap   = (phase_q >= psc_i);
  assign tick_o = run_i & src_tick & wrap & ~phase_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 phase_q <= '0;
    else if (phase_clr_i)        phase_q <= '0;
    else if (run_i && src_tick)  phase_q <= wrap ? '0 : phase_q + 1'b1;
  end

endmodule

// File: rtl/span_timer_count.sv
module span_timer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] end_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_ev_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end   = (cnt_q >= end_i);
  assign ovf_ev_o = tick_i & ~load_i & ~restart_i & at_end;
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_i)    cnt_q <= load_val_i;
    else if (restart_i) cnt_q <= start_i;
    else if (tick_i)    cnt_q <= at_end ? start_i : cnt_q + 1'b1;
  end

endmodule

// File: rtl/span_timer_evt.sv
module span_timer_evt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ovf_ev_i,
  input  logic             ug_i,
  input  logic             upd_off_i,
  input  logic             ovf_only_i,
  input  logic             buf_en_i,
  input  logic             end_wr_i,
  input  logic [CNT_W-1:0] end_val_i,
  input  logic [1:0]       clr_i,
  output logic [CNT_W-1:0] end_act_o,
  output logic             update_o,
  output logic             overflow_o,
  output logic             ovf_flag_o,
  output logic             upd_flag_o
);

  logic [CNT_W-1:0] end_pre_q, end_act_q;
  logic             upd_ev;

  assign upd_ev    = ~upd_off_i & (ovf_ev_i | (ug_i & ~ovf_only_i));
  assign end_act_o = end_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_pre_q <= '1;
      end_act_q <= '1;
    end else begin
      if (end_wr_i) end_pre_q <= end_val_i;
      if (end_wr_i && !buf_en_i) end_act_q <= end_val_i;
      else if (upd_ev)           end_act_q <= end_pre_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      update_o   <= 1'b0;
      overflow_o <= 1'b0;
      ovf_flag_o <= 1'b0;
      upd_flag_o <= 1'b0;
    end else begin
      update_o   <= upd_ev;
      overflow_o <= ovf_ev_i;
      // set wins over a clear in the same cycle
      ovf_flag_o <= ovf_ev_i | (ovf_flag_o & ~clr_i[0]);
      upd_flag_o <= upd_ev   | (upd_flag_o & ~clr_i[1]);
    end
  end

endmodule

// File: rtl/span_timer.sv
module span_timer
  import span_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ugen_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              update_o,
  output logic              overflow_o,
  output logic              ovf_flag_o,
  output logic              upd_flag_o,
  output logic              irq_o,
  output logic              run_o
);

  ctrl_t            ctrl_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] end_act;
  logic             wr_ctrl, wr_psc, wr_start, wr_end, wr_count, wr_flags;
  logic             clr_ovf, clr_upd;
  logic             tick, ovf_ev;

  assign wr_ctrl  = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign wr_psc   = wr_en_i && (wr_sel_i == SEL_PRESC);
  assign wr_start = wr_en_i && (wr_sel_i == SEL_START);
  assign wr_end   = wr_en_i && (wr_sel_i == SEL_END);
  assign wr_count = wr_en_i && (wr_sel_i == SEL_COUNT);
  assign wr_flags = wr_en_i && (wr_sel_i == SEL_FLAGS);
  assign clr_ovf  = wr_flags & wr_data_i[0];
  assign clr_upd  = wr_flags & wr_data_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      psc_q   <= '0;
      start_q <= '0;
    end else begin
      if (wr_ctrl)                           ctrl_q     <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      else if (ovf_ev && ctrl_q.one_shot)    ctrl_q.run <= 1'b0;
      if (wr_psc)   psc_q   <= wr_data_i[PSC_W-1:0];
      if (wr_start) start_q <= wr_data_i[CNT_W-1:0];
    end
  end

  span_timer_tick #(
    .PSC_W       (PSC_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_clk_i   (ext_clk_i),
    .src_i       (ctrl_q.clk_src),
    .run_i       (ctrl_q.run),
    .phase_clr_i (wr_count | ugen_i),
    .psc_i       (psc_q),
    .tick_o      (tick)
  );

  span_timer_count #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (wr_count),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .restart_i  (ugen_i),
    .start_i    (start_q),
    .end_i      (end_act),
    .count_o    (count_o),
    .ovf_ev_o   (ovf_ev)
  );

  span_timer_evt #(
    .CNT_W (CNT_W)
  ) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ovf_ev_i   (ovf_ev),
    .ug_i       (ugen_i),
    .upd_off_i  (ctrl_q.upd_off),
    .ovf_only_i (ctrl_q.ovf_only),
    .buf_en_i   (ctrl_q.buf_en),
    .end_wr_i   (wr_end),
    .end_val_i  (wr_data_i[CNT_W-1:0]),
    .clr_i      ({clr_upd, clr_ovf}),
    .end_act_o  (end_act),
    .update_o   (update_o),
    .overflow_o (overflow_o),
    .ovf_flag_o (ovf_flag_o),
    .upd_flag_o (upd_flag_o)
  );

  assign irq_o = (ovf_flag_o & ctrl_q.ovf_ie) | (upd_flag_o & ctrl_q.upd_ie);
  assign run_o = ctrl_q.run;

endmodule

// File: rtl/span_timer_chk.sv
module span_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] start_q,
  input logic             overflow_o,
  input logic             update_o,
  input logic             ovf_flag_o,
  input logic             run_o,
  input logic             ovf_ev,
  input logic             one_shot,
  input logic             upd_off,
  input logic             ovf_only,
  input logic             wr_ctrl,
  input logic             wr_start,
  input logic             wr_count,
  input logic             clr_ovf,
  input logic             ugen_i
);

  AST_OVF_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !$past(wr_start) |-> count_o == start_q); // R2

  AST_ONE_SHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_ev && one_shot && !wr_ctrl |=> !run_o); // R5

  AST_UG_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ugen_i && !wr_count |=> count_o == $past(start_q)); // R6

  AST_OVF_ONLY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ugen_i && ovf_only |=> !update_o); // R7

  AST_UPD_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_off |=> !update_o); // R8

  AST_OVF_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_flag_o && !clr_ovf |=> ovf_flag_o); // R10

  AST_OVF_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_ev |=> ovf_flag_o && overflow_o); // R10

  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o && !wr_count && !ugen_i |=> $stable(count_o)); // R11

endmodule

bind span_timer span_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .count_o    (count_o),
  .start_q    (start_q),
  .overflow_o (overflow_o),
  .update_o   (update_o),
  .ovf_flag_o (ovf_flag_o),
  .run_o      (run_o),
  .ovf_ev     (ovf_ev),
  .one_shot   (ctrl_q.one_shot),
  .upd_off    (ctrl_q.upd_off),
  .ovf_only   (ctrl_q.ovf_only),
  .wr_ctrl    (wr_ctrl),
  .wr_start   (wr_start),
  .wr_count   (wr_count),
  .clr_ovf    (clr_ovf),
  .ugen_i     (ugen_i)
);

// File: tb/tb_span_timer.sv
`timescale 1ns/1ps
module tb_span_timer;

  localparam int CW = 16;
  localparam int DW = 16;

  localparam logic [2:0] A_CTRL = 3'd0, A_PSC = 3'd1, A_START = 3'd2,
                         A_END = 3'd3, A_CNT = 3'd4, A_FLG = 3'd5;
  localparam int C_RUN = 1, C_ONE = 2, C_UOFF = 4, C_OONLY = 8, C_BUF = 16,
                 C_RISE = 32, C_FALL = 64, C_BOTH = 96, C_OIE = 128, C_UIE = 256;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ext_clk_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    wr_sel_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic          ugen_i = 1'b0;
  logic [CW-1:0] count_o;
  logic          update_o, overflow_o, ovf_flag_o, upd_flag_o, irq_o, run_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk_i = ~clk_i;

  span_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_clk_i(ext_clk_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .ugen_i(ugen_i), .count_o(count_o), .update_o(update_o),
    .overflow_o(overflow_o), .ovf_flag_o(ovf_flag_o), .upd_flag_o(upd_flag_o),
    .irq_o(irq_o), .run_o(run_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] sel, input int data);
    wr_en_i   = 1'b1;
    wr_sel_i  = sel;
    wr_data_i = DW'(data);
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic ug_pulse();
    ugen_i = 1'b1;
    @(negedge clk_i);
    ugen_i = 1'b0;
  endtask

  // returns the last count seen before the overflow sample
  task automatic run_to_ovf(input string req, output int top);
    int prev = int'(count_o);
    top = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (overflow_o) begin
        top = prev;
        return;
      end
      prev = int'(count_o);
    end
    check({req, " overflow timeout"}, 0, 1);
  endtask

  task automatic t_reset();
    check("R1 count", count_o, 0);
    check("R1 run", run_o, 0);
    check("R1 ovf flag", ovf_flag_o, 0);
    check("R1 upd flag", upd_flag_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 pulses", {update_o, overflow_o}, 0);
  endtask

  task automatic t_continuous();
    wr(A_START, 5); wr(A_END, 8); wr(A_CNT, 5); wr(A_CTRL, C_RUN);
    check("R2 first", count_o, 5);
    step(3); check("R2 at end", count_o, 8); check("R2 no ovf", overflow_o, 0);
    step(1); check("R2 wrap", count_o, 5); check("R2 ovf pulse", overflow_o, 1);
    step(1); check("R2 next", count_o, 6); check("R2 pulse width", overflow_o, 0);
    step(2); check("R2 again end", count_o, 8);
    step(1); check("R2 second wrap", count_o, 5); check("R2 second ovf", overflow_o, 1);
  endtask

  task automatic t_prescaler();
    wr(A_CTRL, 0); wr(A_START, 0); wr(A_END, 100); wr(A_PSC, 2); wr(A_CNT, 0);
    wr(A_CTRL, C_RUN);
    check("R3 start", count_o, 0);
    step(2); check("R3 hold", count_o, 0);
    step(1); check("R3 tick1", count_o, 1);
    step(2); check("R3 hold2", count_o, 1);
    step(1); check("R3 tick2", count_o, 2);
  endtask

  task automatic t_freeze_load();
    step(1);
    wr(A_CTRL, 0);
    check("R11 stopped", count_o, 2);
    step(5); check("R11 frozen", count_o, 2);
    wr(A_CTRL, C_RUN);
    check("R11 resume edge", count_o, 2);
    step(1); check("R11 phase kept", count_o, 3);
    wr(A_CNT, 50);
    check("R11 load", count_o, 50);
    step(2); check("R11 phase cleared", count_o, 50);
    step(1); check("R11 after load", count_o, 51);
  endtask

  task automatic t_external();
    wr(A_CTRL, 0); wr(A_PSC, 0); wr(A_CNT, 0); wr(A_CTRL, C_RUN | C_RISE);
    step(4); check("R4 core ignored", count_o, 0);
    ext_clk_i = 1'b1;
    step(2); check("R4 sync delay", count_o, 0);
    step(1); check("R4 rise", count_o, 1);
    step(4); check("R4 level", count_o, 1);
    ext_clk_i = 1'b0;
    step(5); check("R4 fall ignored", count_o, 1);
    wr(A_CTRL, C_RUN | C_FALL);
    ext_clk_i = 1'b1;
    step(5); check("R4 rise ignored", count_o, 1);
    ext_clk_i = 1'b0;
    step(2); check("R4 fall delay", count_o, 1);
    step(1); check("R4 fall", count_o, 2);
    wr(A_CTRL, C_RUN | C_BOTH);
    ext_clk_i = 1'b1;
    step(3); check("R4 both rise", count_o, 3);
    ext_clk_i = 1'b0;
    step(3); check("R4 both fall", count_o, 4);
  endtask

  task automatic t_single();
    wr(A_CTRL, 0); wr(A_START, 0); wr(A_END, 3); wr(A_CNT, 0);
    wr(A_CTRL, C_RUN | C_ONE);
    step(3); check("R5 at end", count_o, 3); check("R5 running", run_o, 1);
    step(1); check("R5 wrap", count_o, 0); check("R5 ovf", overflow_o, 1);
    check("R5 run cleared", run_o, 0);
    step(5); check("R5 stopped", count_o, 0);
  endtask

  task automatic t_ug();
    wr(A_START, 10); wr(A_END, 200); wr(A_CNT, 50); wr(A_FLG, 3); wr(A_CTRL, C_RUN);
    step(3); check("R6 pre", count_o, 53);
    ug_pulse();
    check("R6 restart", count_o, 10);
    check("R6 update pulse", update_o, 1);
    check("R6 upd flag", upd_flag_o, 1);
    check("R6 no ovf flag", ovf_flag_o, 0);
    step(1); check("R6 continue", count_o, 11); check("R6 pulse width", update_o, 0);
  endtask

  task automatic t_ovf_only();
    int top;
    wr(A_FLG, 3); wr(A_CTRL, C_RUN | C_OONLY);
    ug_pulse();
    check("R7 restart", count_o, 10);
    check("R7 no update", update_o, 0);
    check("R7 no flag", upd_flag_o, 0);
    wr(A_END, 12);
    run_to_ovf("R7", top);
    check("R7 ovf update", update_o, 1);
    check("R7 ovf flag", upd_flag_o, 1);
  endtask

  task automatic t_shadow();
    int top;
    wr(A_CTRL, 0); wr(A_START, 0); wr(A_END, 3); wr(A_CNT, 0);
    wr(A_CTRL, C_RUN | C_BUF); wr(A_END, 6);
    run_to_ovf("R9", top); check("R9 old end kept", top, 3);
    run_to_ovf("R9", top); check("R9 buffered end used", top, 6);
    wr(A_CTRL, C_RUN); wr(A_CNT, 0); wr(A_END, 4);
    run_to_ovf("R9", top); check("R9 direct end", top, 4);
  endtask

  task automatic t_upd_off();
    int top;
    wr(A_FLG, 3); wr(A_CTRL, C_RUN | C_BUF | C_UOFF); wr(A_CNT, 0); wr(A_END, 2);
    run_to_ovf("R8", top); check("R8 end", top, 4);
    check("R8 no update", update_o, 0);
    check("R8 ovf flag", ovf_flag_o, 1);
    check("R8 no upd flag", upd_flag_o, 0);
    run_to_ovf("R8", top); check("R8 no reload", top, 4);
    ug_pulse();
    check("R8 ug restart", count_o, 0);
    check("R8 ug no update", update_o, 0);
    check("R8 ug no flag", upd_flag_o, 0);
  endtask

  task automatic t_flags();
    int top;
    wr(A_CTRL, C_RUN);
    run_to_ovf("R10", top);
    wr(A_CTRL, C_OIE);
    step(5);
    check("R10 ovf sticky", ovf_flag_o, 1);
    check("R10 upd sticky", upd_flag_o, 1);
    check("R10 irq ovf", irq_o, 1);
    wr(A_CTRL, 0); check("R10 irq masked", irq_o, 0);
    wr(A_CTRL, C_UIE); check("R10 irq upd", irq_o, 1);
    wr(A_FLG, 0);
    check("R10 zero write ovf", ovf_flag_o, 1);
    check("R10 zero write upd", upd_flag_o, 1);
    wr(A_FLG, 2);
    check("R10 upd cleared", upd_flag_o, 0);
    check("R10 ovf kept", ovf_flag_o, 1);
    check("R10 irq after clear", irq_o, 0);
    wr(A_CTRL, C_OIE); check("R10 irq ovf again", irq_o, 1);
    wr(A_FLG, 1);
    check("R10 ovf cleared", ovf_flag_o, 0);
    check("R10 irq off", irq_o, 0);
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_continuous();
    t_prescaler();
    t_freeze_load();
    t_external();
    t_single();
    t_ug();
    t_ovf_only();
    t_shadow();
    t_upd_off();
    t_flags();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule